// File: doc/BRIEF.md
# Timestamp-Paced Packet Delayer

This block holds the packets of a single queue in a buffer and lets each one go only when a time reference has reached the moment the packet is due. Each packet's start beat carries a timestamp. The block reads that timestamp in one of two ways, chosen by a parameter.

In gap mode, the timestamp is the number of nanoseconds to wait after the previous packet was released. In absolute mode, it is the number of nanoseconds since a reference point. That reference point is taken when the first packet reaches the buffer head after reset or after a time-reset pulse.

Time comes from one of two places. By default it is an internal counter that adds one clock period, in whole nanoseconds, on every cycle. Alternatively, a 64-bit time input from outside the block can be used. Once the first beat of a packet has left, the rest of the packet follows without pacing. The block raises an almost-full flag early enough that an upstream source can still land a fixed number of words after seeing it.

Top module: `pcd_delayer`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0, `in_ready` is 1 and `almost_full` is 0.
- R2: Beats leave in the order they were accepted, with data, start flag and end flag unchanged.
- R3: The internal time source advances by 1e9/CLK_HZ nanoseconds per cycle, which is 5 ns at the default of 200 MHz.
- R4: In gap mode, with data waiting and `out_ready` high, packet k's start beat is accepted max(L, max(1, ceil(ts_k/step))) cycles after packet k-1's start beat. Here L is the beat count of packet k-1.
- R5: In absolute mode, a start beat is released in the first cycle in which elapsed time since the reference point is at least its timestamp. The reference point is not moved by releases.
- R6: The reference point is captured in the cycle after the first start beat reaches the buffer head following reset or a time-reset pulse. A packet with timestamp T then shows `out_valid` ceil(T/step) cycles after its acceptance edge, for T >= step.
- R7: Once a start beat has been accepted, each later beat of that packet is offered in the following cycle whenever it is buffered.
- R8: The buffer holds BUF_BYTES/WORD_BYTES words. `almost_full` is 1 when occupancy is at least depth minus AF_OFF. `in_ready` is 0 only when the buffer is full.
- R9: With EXT_TIME set, `ext_time` replaces the internal counter as the time reference.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and the output beat hold until accepted.
- R11: A time-reset pulse discards the reference point, so the next packet waits its full timestamp from its own arrival at the head, however long ago the last release was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_time | input | 64 | External time in ns, used when EXT_TIME is set |
| time_rst | input | 1 | One-cycle pulse that discards the time reference point |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | WORD_BYTES*8 | Input beat data |
| in_sof | input | 1 | Input beat is the first of a packet |
| in_eof | input | 1 | Input beat is the last of a packet |
| in_ts | input | TS_W | Packet timestamp, meaningful with in_sof |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | WORD_BYTES*8 | Output beat data |
| out_sof | output | 1 | Output beat is the first of a packet |
| out_eof | output | 1 | Output beat is the last of a packet |
| almost_full | output | 1 | Buffer occupancy at or above the early-warning level |

## Verification
A reference point that is captured at the wrong moment, or moved when it should not be, shows at the output as a start beat arriving one or more cycles off the computed release cycle. A reference point that is never cleared lets a packet through at once, where it should wait ceil(T/step) cycles. A pacing state stuck in the middle of a packet would let a start beat out early. A wrongly cleared pacing state would put a gap inside a packet, and that gap is visible on the very next beat. Occupancy errors show as `almost_full` or `in_ready` changing on the wrong push, or as reordered or missing data during a full drain.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

    localparam int TIME_W = 64;

    typedef logic [TIME_W-1:0] ptime_t;

    // How a packet timestamp is read
    typedef enum logic {
        FMT_GAP = 1'b0,   // wait after previous release
        FMT_ABS = 1'b1    // offset from the reference point
    } ts_fmt_e;

    // Pacing state: waiting on a start beat or streaming a packet body
    typedef enum logic {
        GS_HEAD = 1'b0,
        GS_BODY = 1'b1
    } gate_st_e;

    function automatic ptime_t ns_per_cycle(input int unsigned hz);
        return ptime_t'(64'd1_000_000_000 / 64'(hz));
    endfunction

    function automatic int unsigned words_of(input int unsigned bytes, input int unsigned wb);
        return (bytes + wb - 1) / wb;
    endfunction

endpackage

// File: rtl/pcd_timebase.sv
module pcd_timebase
    import pcd_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 200_000_000,
    parameter bit          EXT_TIME = 1'b0
) (
    input  logic   clk,
    input  logic   rst,
    input  ptime_t ext_time,
    output ptime_t now
);

    localparam ptime_t STEP = ns_per_cycle(CLK_HZ);

    generate
        if (EXT_TIME) begin : g_ext
            logic unused_clkrst;
            assign unused_clkrst = clk ^ rst;
            assign now = ext_time;
        end else begin : g_int
            ptime_t cnt_q;
            logic   unused_ext;
            assign unused_ext = ^ext_time;

            always_ff @(posedge clk) begin
                if (rst) cnt_q <= '0;
                else     cnt_q <= cnt_q + STEP;
            end
            assign now = cnt_q;

            // R3: internal time grows by exactly one period per cycle
            a_r3_step: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> now == $past(now) + STEP);
        end
    endgenerate

endmodule

// File: rtl/pcd_fifo.sv
module pcd_fifo #(
    parameter int W      = 8,
    parameter int DEPTH  = 16,
    parameter int AF_OFF = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         valid,
    output logic         full,
    output logic         almost_full
);

    localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW     = $clog2(DEPTH + 1);
    localparam int AF_THR = DEPTH - AF_OFF;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          do_wr, do_rd;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full        = (cnt_q == CW'(DEPTH));
    assign valid       = (cnt_q != '0);
    assign almost_full = (cnt_q >= CW'(AF_THR));
    assign do_wr       = push && !full;
    assign do_rd       = pop && valid;
    assign dout        = mem[rd_q];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_wr) wr_q <= nxt(wr_q);
            if (do_rd) rd_q <= nxt(rd_q);
            case ({do_wr, do_rd})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R8: occupancy never passes the depth
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

    // R8: the early warning is up before the buffer fills
    a_r8_af_before_full: assert property (@(posedge clk) disable iff (rst)
        $rose(full) |-> $past(almost_full));

    // R2: an accepted word is visible at the head side next cycle
    a_r2_push_visible: assert property (@(posedge clk) disable iff (rst)
        do_wr |=> valid);

endmodule

// File: rtl/pcd_gate.sv
module pcd_gate
    import pcd_pkg::*;
#(
    parameter ts_fmt_e FMT  = FMT_GAP,
    parameter int      TS_W = 48
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            time_rst,
    input  ptime_t          now,
    input  logic            head_valid,
    input  logic            head_sof,
    input  logic            head_eof,
    input  logic [TS_W-1:0] head_ts,
    input  logic            out_ready,
    output logic            out_valid,
    output logic            pop
);

    gate_st_e st_q;
    logic     armed_q;
    ptime_t   base_q;
    ptime_t   elapsed;
    logic     due;

    assign elapsed   = now - base_q;
    assign due       = armed_q && (elapsed >= ptime_t'(head_ts));
    assign out_valid = head_valid && ((st_q == GS_BODY) || due);
    assign pop       = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= GS_HEAD;
            armed_q <= 1'b0;
            base_q  <= '0;
        end else begin
            if (pop) st_q <= head_eof ? GS_HEAD : GS_BODY;

            if (time_rst) begin
                armed_q <= 1'b0;
            end else if (!armed_q && head_valid && head_sof && st_q == GS_HEAD) begin
                armed_q <= 1'b1;
                base_q  <= now;
            end else if (FMT == FMT_GAP && pop && st_q == GS_HEAD) begin
                base_q  <= now;
            end
        end
    end

    // R11: after a time-reset no start beat is offered in the next cycle
    a_r11_disarm: assert property (@(posedge clk) disable iff (rst)
        time_rst |=> (st_q == GS_BODY) || !out_valid);

endmodule

// File: rtl/pcd_delayer.sv
module pcd_delayer
    import pcd_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 200_000_000,
    parameter bit          EXT_TIME   = 1'b0,
    parameter ts_fmt_e     FMT        = FMT_GAP,
    parameter int          TS_W       = 48,
    parameter int          BUF_BYTES  = 2048,
    parameter int          WORD_BYTES = 8,
    parameter int          AF_OFF     = 10,
    localparam int         DATA_W     = WORD_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [63:0]       ext_time,
    input  logic              time_rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [TS_W-1:0]   in_ts,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sof,
    output logic              out_eof,
    output logic              almost_full
);

    localparam int DEPTH = int'(words_of(BUF_BYTES, WORD_BYTES));

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              sof;
        logic              eof;
        logic [TS_W-1:0]   ts;
    } beat_t;

    localparam int BW = $bits(beat_t);

    beat_t  wr_beat, rd_beat;
    logic   head_valid, full, pop;
    ptime_t now;

    assign wr_beat = '{data: in_data, sof: in_sof, eof: in_eof, ts: in_ts};
    assign in_ready = !full;

    pcd_timebase #(
        .CLK_HZ   (CLK_HZ),
        .EXT_TIME (EXT_TIME)
    ) u_time (
        .clk      (clk),
        .rst      (rst),
        .ext_time (ext_time),
        .now      (now)
    );

    pcd_fifo #(
        .W      (BW),
        .DEPTH  (DEPTH),
        .AF_OFF (AF_OFF)
    ) u_buf (
        .clk         (clk),
        .rst         (rst),
        .push        (in_valid),
        .din         (wr_beat),
        .pop         (pop),
        .dout        (rd_beat),
        .valid       (head_valid),
        .full        (full),
        .almost_full (almost_full)
    );

    pcd_gate #(
        .FMT  (FMT),
        .TS_W (TS_W)
    ) u_gate (
        .clk        (clk),
        .rst        (rst),
        .time_rst   (time_rst),
        .now        (now),
        .head_valid (head_valid),
        .head_sof   (rd_beat.sof),
        .head_eof   (rd_beat.eof),
        .head_ts    (rd_beat.ts),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .pop        (pop)
    );

    assign out_data = rd_beat.data;
    assign out_sof  = rd_beat.sof;
    assign out_eof  = rd_beat.eof;

    // R10: a stalled beat stays offered and unchanged
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready && !time_rst |=>
            out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof));

endmodule

// File: tb/pcd_delayer_tb.sv
module pcd_delayer_tb_top;
    import pcd_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // dut_i: internal time, gap mode, default buffer
    logic [63:0] i_ext = '0;
    logic        i_trst = 1'b0;
    logic        i_in_valid = 1'b0, i_in_ready, i_in_sof = 1'b0, i_in_eof = 1'b0;
    logic [63:0] i_in_data = '0;
    logic [47:0] i_in_ts = '0;
    logic        i_out_valid, i_out_ready = 1'b0, i_out_sof, i_out_eof, i_af;
    logic [63:0] i_out_data;

    // dut_x: external time, absolute mode
    logic [63:0] x_ext = '0;
    logic        x_in_valid = 1'b0, x_in_ready, x_in_sof = 1'b0, x_in_eof = 1'b0;
    logic [63:0] x_in_data = '0;
    logic [47:0] x_in_ts = '0;
    logic        x_out_valid, x_out_ready = 1'b1, x_out_sof, x_out_eof, x_af;
    logic [63:0] x_out_data;

    pcd_delayer dut_i (
        .clk(clk), .rst(rst), .ext_time(i_ext), .time_rst(i_trst),
        .in_valid(i_in_valid), .in_ready(i_in_ready), .in_data(i_in_data),
        .in_sof(i_in_sof), .in_eof(i_in_eof), .in_ts(i_in_ts),
        .out_valid(i_out_valid), .out_ready(i_out_ready), .out_data(i_out_data),
        .out_sof(i_out_sof), .out_eof(i_out_eof), .almost_full(i_af)
    );

    pcd_delayer #(.EXT_TIME(1'b1), .FMT(FMT_ABS), .BUF_BYTES(256)) dut_x (
        .clk(clk), .rst(rst), .ext_time(x_ext), .time_rst(1'b0),
        .in_valid(x_in_valid), .in_ready(x_in_ready), .in_data(x_in_data),
        .in_sof(x_in_sof), .in_eof(x_in_eof), .in_ts(x_in_ts),
        .out_valid(x_out_valid), .out_ready(x_out_ready), .out_data(x_out_data),
        .out_sof(x_out_sof), .out_eof(x_out_eof), .almost_full(x_af)
    );

    // Gap-mode vectors: beats per packet, timestamp, expected start-to-start gap
    localparam int NV = 7;
    localparam int VLEN [NV] = '{1, 2, 1, 3, 1, 2, 1};
    localparam int VTS  [NV] = '{0, 20, 3, 0, 47, 5, 100};
    localparam int VGAP [NV] = '{0, 4, 2, 1, 10, 1, 20};

    // Absolute-mode vectors (external time +7 ns per cycle): ts, delay after first
    localparam int NX = 5;
    localparam int XTS  [NX] = '{0, 30, 100, 100, 101};
    localparam int XDEL [NX] = '{0, 4, 14, 15, 16};

    int          rec_cyc  [64];
    logic [63:0] rec_data [64];
    logic        rec_sof  [64];
    logic        rec_eof  [64];
    int          nrec;

    initial forever begin
        @(posedge clk);
        cyc++;
        #1 x_ext = x_ext + 64'd7;
    end

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        finish_up();
    end

    task automatic check(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push_i(input logic [63:0] d, input logic s, input logic e, input logic [47:0] t);
        logic rdy;
        i_in_valid = 1'b1; i_in_data = d; i_in_sof = s; i_in_eof = e; i_in_ts = t;
        forever begin
            rdy = i_in_ready;
            @(posedge clk);
            @(negedge clk);
            if (rdy) break;
        end
        i_in_valid = 1'b0;
    endtask

    task automatic push_x(input logic [63:0] d, input logic [47:0] t);
        logic rdy;
        x_in_valid = 1'b1; x_in_data = d; x_in_sof = 1'b1; x_in_eof = 1'b1; x_in_ts = t;
        forever begin
            rdy = x_in_ready;
            @(posedge clk);
            @(negedge clk);
            if (rdy) break;
        end
        x_in_valid = 1'b0;
    endtask

    initial begin
        int b;
        int sof_prev;
        logic [63:0] d0;
        int idx;
        int bad;
        int n;

        repeat (3) @(negedge clk);
        check(i_out_valid == 1'b0, "R1 out_valid in reset", i_out_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        check(i_out_valid == 1'b0, "R1 out_valid after reset", i_out_valid, 0);
        check(i_in_ready == 1'b1, "R1 in_ready after reset", i_in_ready, 1);
        check(i_af == 1'b0, "R1 almost_full after reset", i_af, 0);

        // Preload gap-mode packets with output stalled
        for (int k = 0; k < NV; k++)
            for (int j = 0; j < VLEN[k]; j++)
                push_i(64'(k * 16 + j), j == 0, j == VLEN[k] - 1, 48'(VTS[k]));

        d0 = i_out_data;
        repeat (3) @(negedge clk);
        check(i_out_valid && i_out_data == d0, "R10 stalled beat held", i_out_data, d0);

        i_out_ready = 1'b1;
        nrec = 0;
        repeat (80) begin
            if (i_out_valid && i_out_ready && nrec < 64) begin
                rec_cyc[nrec] = cyc; rec_data[nrec] = i_out_data;
                rec_sof[nrec] = i_out_sof; rec_eof[nrec] = i_out_eof;
                nrec++;
            end
            @(negedge clk);
        end

        b = 0;
        sof_prev = 0;
        for (int k = 0; k < NV; k++) begin
            for (int j = 0; j < VLEN[k]; j++) begin
                check(rec_data[b] == 64'(k * 16 + j) && rec_sof[b] == (j == 0) && rec_eof[b] == (j == VLEN[k] - 1),
                      "R2 beat order and flags", rec_data[b], k * 16 + j);
                if (j > 0)
                    check(rec_cyc[b] == rec_cyc[b-1] + 1, "R7 body beat follows next cycle",
                          rec_cyc[b] - rec_cyc[b-1], 1);
                else if (k > 0)
                    check(rec_cyc[b] - sof_prev == VGAP[k], "R4 R3 start gap", rec_cyc[b] - sof_prev, VGAP[k]);
                if (j == 0) sof_prev = rec_cyc[b];
                b++;
            end
        end
        check(nrec == b, "R2 beat count", nrec, b);

        // Fill to almost-full and full with the output stalled
        i_out_ready = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 245; i++) push_i(64'(1000 + i), 1'b1, 1'b1, 48'd0);
        check(i_af == 1'b0, "R8 almost_full low at 245 words", i_af, 0);
        push_i(64'(1245), 1'b1, 1'b1, 48'd0);
        check(i_af == 1'b1, "R8 almost_full high at 246 words", i_af, 1);
        for (int i = 246; i < 255; i++) push_i(64'(1000 + i), 1'b1, 1'b1, 48'd0);
        check(i_in_ready == 1'b1, "R8 in_ready high at 255 words", i_in_ready, 1);
        push_i(64'(1255), 1'b1, 1'b1, 48'd0);
        check(i_in_ready == 1'b0, "R8 in_ready low when full", i_in_ready, 0);

        i_out_ready = 1'b1;
        idx = 0;
        bad = 0;
        repeat (400) begin
            if (i_out_valid && idx < 256) begin
                if (i_out_data != 64'(1000 + idx)) bad++;
                idx++;
            end
            @(negedge clk);
        end
        check(bad == 0, "R2 drain order", bad, 0);
        check(idx == 256, "R8 drained word count", idx, 256);

        // Long idle: reference point still armed, packet leaves at once
        repeat (20) @(negedge clk);
        push_i(64'd77, 1'b1, 1'b1, 48'd50);
        n = 0;
        while (!i_out_valid && n < 200) begin @(negedge clk); n++; end
        check(n == 0, "R4 overdue packet not delayed", n, 0);
        @(negedge clk);

        // Time reset: next packet waits its full timestamp from head arrival
        i_trst = 1'b1;
        @(negedge clk);
        i_trst = 1'b0;
        push_i(64'd88, 1'b1, 1'b1, 48'd50);
        n = 0;
        while (!i_out_valid && n < 200) begin @(negedge clk); n++; end
        check(n == 10, "R11 R6 wait after time reset", n, 10);
        check(i_out_data == 64'd88, "R6 delayed packet data", i_out_data, 88);
        @(negedge clk);

        // Absolute mode with external time
        nrec = 0;
        fork
            begin
                for (int k = 0; k < NX; k++) push_x(64'(500 + k), 48'(XTS[k]));
            end
            begin
                repeat (40) begin
                    if (x_out_valid && x_out_ready && nrec < 64) begin
                        rec_cyc[nrec] = cyc; rec_data[nrec] = x_out_data;
                        nrec++;
                    end
                    @(negedge clk);
                end
            end
        join
        check(nrec == NX, "R5 absolute-mode packet count", nrec, NX);
        for (int k = 0; k < NX; k++) begin
            check(rec_data[k] == 64'(500 + k), "R2 absolute-mode order", rec_data[k], 500 + k);
            check(rec_cyc[k] - rec_cyc[0] == XDEL[k], "R5 R9 absolute release cycle",
                  rec_cyc[k] - rec_cyc[0], XDEL[k]);
        end

        finish_up();
    end

endmodule